// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Host Parking

This block decides which of six PCI bus agents may drive the shared bus next. Each agent raises a request line; the arbiter answers with exactly one registered grant line. The agents are the host bridge, the upper expansion slot, the ISA bridge, the SCSI controller, the Ethernet controller and the lower expansion slot. Their relative ranking is held in a writable order register that comes out of reset with the host bridge on top and the lower expansion slot at the bottom.

The arbiter only moves the grant when the bus is idle. While a transaction is in progress it holds the current grant. If nobody eligible is asking, the grant rests on the host bridge so that it can start a cycle without waiting. When the current owner is retried by a target, the arbiter pulls the grant away at once. That agent is then shut out of arbitration until it has released its request for at least one clock.

Top module: `pci_prio_arbiter`

## Requirements
- R1: Agent indices are host bridge 0, upper slot 1, ISA bridge 2, SCSI 3, Ethernet 4, lower slot 1 → 5. Grant bit i belongs to agent i. The order word holds the agent index of rank r in bits [3r+2:3r], and rank 0 is the highest. After reset the grant is 6'b000001 and the order read-back is 18'h2C688 (rank r holds agent r).
- R2: In a cycle with the bus idle and no retry, the grant after the next clock edge goes to the highest-ranked agent that is requesting and not shut out.
- R3: In a cycle with the bus idle, no retry, and no eligible request, the grant after the next clock edge is 6'b000001 (parked on the host bridge).
- R4: At most one grant bit is high in any cycle.
- R5: A cycle with retry asserted clears every grant bit after the next clock edge.
- R6: The agent that held the grant in a retry cycle is excluded from arbitration until a cycle in which its request is low. Its next grant can come in the cycle after that low request at the earliest.
- R7: In a cycle with the bus busy and no retry, the grant does not change across the next clock edge, whatever the requests are.
- R8: A write of a legal order word takes effect on the next clock edge. It sets both the read-back and the ranking used for arbitration.
- R9: An order word that names an index of 6 or more, or names any agent twice, is not used. The read-back and the arbitration then follow the reset order 18'h2C688.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Request from each agent, active high |
| bus_idle_i | input | 1 | High when no transaction is under way on the bus |
| retry_i | input | 1 | High for a cycle in which the current owner is retried |
| prio_we_i | input | 1 | Write strobe for the order register |
| prio_wdata_i | input | 18 | Order word to write, 3 bits per rank |
| gnt_o | output | 6 | Registered grant to each agent, active high |
| prio_order_o | output | 18 | Effective order in use (read-back) |

## Verification
Some properties are checked on every cycle. The grants stay mutually exclusive, a busy bus freezes the grant, a retry clears it, and an idle bus with no requests parks it on the host bridge. Which agent wins under a given ranking can only be shown by the bench's scenarios. The same holds for the fallback of illegal order words and for the shut-out of a retried agent until it drops its request. The bench sweeps all 64 request patterns under several legal and illegal orders, then walks through retry and busy-bus sequences.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int AGENTS  = 6;
    localparam int IDX_W   = $clog2(AGENTS);
    localparam int ORDER_W = AGENTS * IDX_W;
    localparam int HOST    = 0;

    typedef logic [AGENTS-1:0] vec_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef idx_t [AGENTS-1:0] order_t;

    typedef enum logic [IDX_W-1:0] {
        AG_HOST  = 3'd0,
        AG_SLOT2 = 3'd1,
        AG_ISA   = 3'd2,
        AG_SCSI  = 3'd3,
        AG_ETH   = 3'd4,
        AG_SLOT1 = 3'd5
    } agent_e;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    // Rank r names agent r after reset.
    function automatic order_t default_order();
        order_t o;
        for (int r = 0; r < AGENTS; r++) o[r] = idx_t'(r);
        return o;
    endfunction

    // Legal when every rank names a real agent and no agent appears twice.
    function automatic logic order_ok(order_t o);
        logic [(1<<IDX_W)-1:0] seen;
        logic ok;
        seen = '0;
        ok   = 1'b1;
        for (int r = 0; r < AGENTS; r++) begin
            if (int'(o[r]) >= AGENTS) ok = 1'b0;
            else if (seen[o[r]])      ok = 1'b0;
            seen[o[r]] = 1'b1;
        end
        return ok;
    endfunction

    function automatic vec_t onehot(idx_t i);
        return vec_t'(1) << i;
    endfunction
endpackage

// File: rtl/arb_prio_reg.sv
module arb_prio_reg
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  order_t wdata,
    output order_t order_eff
);
    order_t raw_q;

    always_ff @(posedge clk) begin
        if (rst)     raw_q <= default_order();
        else if (we) raw_q <= wdata;
    end

    assign order_eff = order_ok(raw_q) ? raw_q : default_order();
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
(
    input  vec_t   eligible,
    input  order_t order,
    output pick_t  winner
);
    always_comb begin
        winner = '0;
        // Walk from lowest rank upward so the highest rank overrides.
        for (int r = AGENTS - 1; r >= 0; r--) begin
            if (eligible[order[r]]) begin
                winner.valid = 1'b1;
                winner.idx   = order[r];
            end
        end
    end
endmodule

// File: rtl/arb_release_track.sv
module arb_release_track
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t req,
    input  logic retry,
    input  vec_t owner,
    output vec_t blocked
);
    vec_t blocked_q;

    // Set for the retried owner; cleared once its request is seen low.
    always_ff @(posedge clk) begin
        if (rst) blocked_q <= '0;
        else     blocked_q <= (blocked_q & req) | (retry ? owner : '0);
    end

    assign blocked = blocked_q;
endmodule

// File: rtl/pci_prio_arbiter.sv
module pci_prio_arbiter
    import arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AGENTS-1:0]     req_i,
    input  logic                  bus_idle_i,
    input  logic                  retry_i,
    input  logic                  prio_we_i,
    input  logic [ORDER_W-1:0]    prio_wdata_i,
    output logic [AGENTS-1:0]     gnt_o,
    output logic [ORDER_W-1:0]    prio_order_o
);
    order_t order_eff;
    vec_t   blocked;
    vec_t   eligible;
    pick_t  winner;
    vec_t   gnt_q;
    vec_t   gnt_n;

    arb_prio_reg u_prio (
        .clk       (clk),
        .rst       (rst),
        .we        (prio_we_i),
        .wdata     (order_t'(prio_wdata_i)),
        .order_eff (order_eff)
    );

    arb_release_track u_rel (
        .clk     (clk),
        .rst     (rst),
        .req     (req_i),
        .retry   (retry_i),
        .owner   (gnt_q),
        .blocked (blocked)
    );

    assign eligible = req_i & ~blocked;

    arb_pick u_pick (
        .eligible (eligible),
        .order    (order_eff),
        .winner   (winner)
    );

    always_comb begin
        if (retry_i)
            gnt_n = '0;
        else if (bus_idle_i)
            gnt_n = winner.valid ? onehot(winner.idx) : onehot(idx_t'(HOST));
        else
            gnt_n = gnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) gnt_q <= onehot(idx_t'(HOST));
        else     gnt_q <= gnt_n;
    end

    assign gnt_o        = gnt_q;
    assign prio_order_o = order_eff;
endmodule

// File: rtl/pci_prio_arbiter_chk.sv
module pci_prio_arbiter_chk
    import arb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [AGENTS-1:0]  req_i,
    input logic               bus_idle_i,
    input logic               retry_i,
    input logic [AGENTS-1:0]  gnt_o,
    input logic [ORDER_W-1:0] prio_order_o
);
    localparam logic [AGENTS-1:0] HOST_GNT = AGENTS'(1) << HOST;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gnt_o == HOST_GNT && prio_order_o == ORDER_W'(default_order())));

    assert_grant_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    assert_retry_drop_R5: assert property (@(posedge clk) disable iff (rst)
        retry_i |=> (gnt_o == '0));

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus_idle_i && !retry_i) |=> $stable(gnt_o));

    assert_park_host_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_idle_i && !retry_i && req_i == '0) |=> (gnt_o == HOST_GNT));
endmodule

bind pci_prio_arbiter pci_prio_arbiter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .bus_idle_i   (bus_idle_i),
    .retry_i      (retry_i),
    .gnt_o        (gnt_o),
    .prio_order_o (prio_order_o)
);

// File: tb/sim_pci_prio_arbiter.sv
module sim_pci_prio_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] DEF_WORD = 18'h2C688;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  req;
    logic        idle;
    logic        retry;
    logic        we;
    logic [17:0] wdata;
    logic [5:0]  gnt;
    logic [17:0] order_rd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_prio_arbiter u0 (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .bus_idle_i   (idle),
        .retry_i      (retry),
        .prio_we_i    (we),
        .prio_wdata_i (wdata),
        .gnt_o        (gnt),
        .prio_order_o (order_rd)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [17:0] pack_order(input int o[6]);
        logic [17:0] w = '0;
        for (int r = 0; r < 6; r++) w[3*r +: 3] = 3'(o[r]);
        return w;
    endfunction

    function automatic logic [5:0] exp_gnt(input logic [5:0] r, input int o[6]);
        for (int k = 0; k < 6; k++)
            if (r[o[k]]) return 6'b1 << o[k];
        return 6'b000001;
    endfunction

    task automatic write_order(input logic [17:0] w);
        we = 1'b1; wdata = w; req = '0; idle = 1'b1;
        step();
        we = 1'b0;
    endtask

    task automatic sweep(input string tag, input int o[6]);
        for (int p = 0; p < 64; p++) begin
            req = 6'(p); idle = 1'b1; retry = 1'b0;
            step();
            // R2 winner by rank, R3 park when p==0
            check(tag, {26'b0, gnt}, {26'b0, exp_gnt(6'(p), o)});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int def_o[6] = '{0, 1, 2, 3, 4, 5};
        int rev_o[6] = '{5, 4, 3, 2, 1, 0};
        int rot_o[6] = '{3, 4, 5, 0, 1, 2};
        int dup_o[6] = '{0, 0, 1, 2, 3, 4};
        int big_o[6] = '{7, 1, 2, 3, 4, 5};

        rst = 1'b1; req = '0; idle = 1'b1; retry = 1'b0; we = 1'b0; wdata = '0;
        step(); step();
        rst = 1'b0;
        check("R1 reset grant", {26'b0, gnt}, 32'h1);
        check("R1 reset order", {14'b0, order_rd}, {14'b0, DEF_WORD});

        sweep("R2 default order", def_o);

        write_order(pack_order(rev_o));
        check("R8 readback reversed", {14'b0, order_rd}, {14'b0, pack_order(rev_o)});
        sweep("R8 reversed order", rev_o);

        write_order(pack_order(rot_o));
        check("R8 readback rotated", {14'b0, order_rd}, {14'b0, pack_order(rot_o)});
        sweep("R8 rotated order", rot_o);

        write_order(pack_order(dup_o));
        check("R9 duplicate falls back", {14'b0, order_rd}, {14'b0, DEF_WORD});
        sweep("R9 duplicate arbitration", def_o);

        write_order(pack_order(rot_o));
        write_order(pack_order(big_o));
        check("R9 out-of-range falls back", {14'b0, order_rd}, {14'b0, DEF_WORD});

        // R4: one grant at most
        req = 6'b111111; step();
        check("R4 single grant", $countones(gnt), 1);

        // Retry sequence on the upper slot (agent 1)
        req = 6'b000010; idle = 1'b1; retry = 1'b0; step();
        check("R2 slot granted", {26'b0, gnt}, 32'h02);
        idle = 1'b0; retry = 1'b1; step();
        check("R5 retry clears grant", {26'b0, gnt}, 32'h00);
        retry = 1'b0; idle = 1'b1; step();
        check("R6 retried agent shut out", {26'b0, gnt}, 32'h01);
        step();
        check("R6 still shut out", {26'b0, gnt}, 32'h01);
        req = 6'b000000; step();
        check("R3 park on release", {26'b0, gnt}, 32'h01);
        req = 6'b000010; step();
        check("R6 eligible after release", {26'b0, gnt}, 32'h02);

        // Busy bus holds the grant
        idle = 1'b0; req = 6'b000001; step();
        check("R7 hold while busy", {26'b0, gnt}, 32'h02);
        req = 6'b111101; step();
        check("R7 hold under new requests", {26'b0, gnt}, 32'h02);
        idle = 1'b1; req = 6'b000011; step();
        check("R2 host wins when idle", {26'b0, gnt}, 32'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule